// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Model

This block stands in for a bank of one-time-programmable fuses so that a fuse programming controller can be exercised against something that behaves like the real array. Each bit keeps a count of the clock cycles for which the burn enable has been applied to it. A bit becomes blown, and reads 1, once that count reaches a minimum programming time. A pulse that is too short leaves the bit reading 0, but the partial time is kept and adds to later pulses. An unblown bit reads 0.

The model also watches for misuse. Starting a new programming pulse on a bit that is already blown is flagged. Driving a bit past its maximum cumulative programming time is flagged as well. Both flags are sticky and keep the address of the first bit that caused them. If the controller reset arrives while the burn enable is high, the addressed bit is marked indeterminate. From then on it reads back a configurable value and raises a separate indeterminate indication.

The controller reset does not clear the fuse contents, the time counters or the flags. Only a separate power-on initialisation input clears them. A read port returns the state of any bit at any time.

Top module: `otp_fuse_model`

## Requirements
- R1: After power-on initialisation (por_n low), every bit reads 0 with rd_indet 0, every time count is zero, and both error flags are 0.
- R2: A clock edge with rst_n high and burn_en high adds exactly one cycle to the time count of the bit at burn_addr. The counts of all other bits are left unchanged.
- R3: A bit reads 1 from the edge on which its count reaches T_MIN (default 4), and it never returns to 0 except through power-on initialisation. A bit whose count is below T_MIN reads 0, and pulses separated by idle cycles add together.
- R4: A pulse starts when burn_en is high with rst_n high and either burn_en was low on the previous edge or burn_addr differs from the previous edge. A pulse that starts on a bit already blown sets err_double. Holding burn_en on the same bit after it blows is not an error.
- R5: err_overtime is set on the edge where a bit's count would exceed T_MAX (default 10), that is, on its (T_MAX+1)-th programming cycle.
- R6: Both error flags are sticky. err_double_addr and err_overtime_addr hold the burn_addr of the edge that first set their flag, and later offences do not change them.
- R7: While rst_n is low, the fuse states, time counts and error flags keep their values. A low pulse on por_n clears all of them.
- R8: An edge with rst_n low and burn_en high marks the bit at burn_addr indeterminate and adds no programming time. From then on, that bit reads INDET_VAL (default 1) with rd_indet 1, until power-on initialisation.
- R9: With READ_REG at 0 (the default), rd_data and rd_indet show the state of the bit at rd_addr combinationally, for any address and at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Controller reset, active low; does not clear fuse contents |
| por_n | input | 1 | Power-on initialisation, active low, asynchronous; clears everything |
| burn_addr | input | AW | Address of the bit being programmed |
| burn_en | input | 1 | Programming enable from the controller |
| rd_addr | input | AW | Address of the bit being read |
| rd_data | output | 1 | Read value: 0 unblown, 1 blown, INDET_VAL if indeterminate |
| rd_indet | output | 1 | Addressed bit is indeterminate |
| err_double | output | 1 | Sticky: a pulse was started on an already blown bit |
| err_double_addr | output | AW | Address of the first double-programming offence |
| err_overtime | output | 1 | Sticky: a bit exceeded its maximum programming time |
| err_overtime_addr | output | AW | Address of the first over-time offence |

## Verification
The bench targets four boundaries. The first is the cycle count one short of T_MIN and the count exactly at it: an off-by-one there would blow bits early or leave them unblown. The second is a continuous pulse held through the blow point, which a careless pulse detector would report as double programming. The third is the T_MAX and T_MAX+1 boundary, together with a second offender that must not overwrite the first recorded address. The fourth covers the reset cases. A controller reset that cleared the array, or a reset with burn enable high that failed to mark the bit indeterminate, would show up as wrong read data on the sweep of all addresses that follows.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

   // Which misuse a sticky error latch records
   typedef enum logic [0:0] {
      ERR_KIND_DOUBLE   = 1'b0,
      ERR_KIND_OVERTIME = 1'b1
   } err_kind_e;

   // Counter width able to hold t_max + 1 (saturation point)
   function automatic int unsigned fuse_cnt_width(input int unsigned t_max);
      return $clog2(t_max + 2);
   endfunction

endpackage

// File: rtl/otp_fuse_cell.sv
module otp_fuse_cell #(
   parameter int unsigned T_MIN = 4,
   parameter int unsigned T_MAX = 10,
   parameter int unsigned CW    = 4
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          burn_hit,
   input  logic          rst_burn_hit,
   output logic          blown_o,
   output logic          indet_o,
   output logic          over_o,
   output logic [CW-1:0] acc_o
);

   localparam logic [CW-1:0] BLOW_AT = CW'(T_MIN - 1);
   localparam logic [CW-1:0] OVER_AT = CW'(T_MAX);
   localparam logic [CW-1:0] SAT_AT  = CW'(T_MAX + 1);

   logic [CW-1:0] acc_q;
   logic          blown_q;
   logic          indet_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         acc_q   <= '0;
         blown_q <= 1'b0;
         indet_q <= 1'b0;
      end else begin
         if (burn_hit) begin
            if (acc_q < SAT_AT) begin
               acc_q <= acc_q + 1'b1;
            end
            if (acc_q >= BLOW_AT) begin
               blown_q <= 1'b1;
            end
         end
         if (rst_burn_hit) begin
            indet_q <= 1'b1;
         end
      end
   end

   assign blown_o = blown_q;
   assign indet_o = indet_q;
   assign over_o  = burn_hit && (acc_q >= OVER_AT);
   assign acc_o   = acc_q;

endmodule

// File: rtl/otp_fuse_pulse_det.sv
module otp_fuse_pulse_det #(
   parameter int unsigned AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          burn_en,
   input  logic [AW-1:0] burn_addr,
   output logic          start_o
);

   logic          prev_en_q;
   logic [AW-1:0] prev_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_en_q   <= 1'b0;
         prev_addr_q <= '0;
      end else begin
         prev_en_q   <= burn_en;
         prev_addr_q <= burn_addr;
      end
   end

   assign start_o = burn_en && (!prev_en_q || (prev_addr_q != burn_addr));

endmodule

// File: rtl/otp_fuse_err_latch.sv
module otp_fuse_err_latch
   import otp_fuse_pkg::*;
#(
   parameter int unsigned AW   = 5,
   parameter err_kind_e   KIND = ERR_KIND_DOUBLE
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          hit,
   input  logic [AW-1:0] hit_addr,
   output logic          flag_o,
   output logic [AW-1:0] addr_o
);

   logic          flag_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         flag_q <= 1'b0;
         addr_q <= '0;
      end else if (hit && !flag_q) begin
         flag_q <= 1'b1;
         addr_q <= hit_addr;
      end
   end

   assign flag_o = flag_q;
   assign addr_o = addr_q;

   if (KIND != ERR_KIND_DOUBLE && KIND != ERR_KIND_OVERTIME) begin : g_bad_kind
      $error("otp_fuse_err_latch: unknown error kind");
   end

endmodule

// File: rtl/otp_fuse_model.sv
module otp_fuse_model
   import otp_fuse_pkg::*;
#(
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned T_MIN     = 4,
   parameter int unsigned T_MAX     = 10,
   parameter bit          INDET_VAL = 1'b1,
   parameter bit          READ_REG  = 1'b0,
   localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          por_n,
   input  logic [AW-1:0] burn_addr,
   input  logic          burn_en,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_data,
   output logic          rd_indet,
   output logic          err_double,
   output logic [AW-1:0] err_double_addr,
   output logic          err_overtime,
   output logic [AW-1:0] err_overtime_addr
);

   localparam int unsigned CW = fuse_cnt_width(T_MAX);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_chk_depth
      $error("otp_fuse_model: DEPTH must be at least 2");
   end
   if (T_MIN < 1) begin : g_chk_tmin
      $error("otp_fuse_model: T_MIN must be at least 1");
   end
   if (T_MAX < T_MIN) begin : g_chk_tmax
      $error("otp_fuse_model: T_MAX must not be below T_MIN");
   end

   logic [DEPTH-1:0] blown_vec;
   logic [DEPTH-1:0] indet_vec;
   logic [DEPTH-1:0] over_vec;
   logic [DEPTH-1:0] hit_vec;
   logic [DEPTH-1:0] rst_hit_vec;
   logic [CW-1:0]    acc_arr [DEPTH];

   logic addr_ok;
   logic rd_ok;
   logic pulse_start;
   logic blown_at_burn;
   logic double_hit;
   logic over_hit;

   assign addr_ok = (32'(burn_addr) < DEPTH);
   assign rd_ok   = (32'(rd_addr) < DEPTH);

   otp_fuse_pulse_det #(.AW(AW)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .burn_en   (burn_en),
      .burn_addr (burn_addr),
      .start_o   (pulse_start)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      assign hit_vec[i]     = rst_n  && burn_en && (burn_addr == AW'(i));
      assign rst_hit_vec[i] = !rst_n && burn_en && (burn_addr == AW'(i));

      otp_fuse_cell #(
         .T_MIN (T_MIN),
         .T_MAX (T_MAX),
         .CW    (CW)
      ) u_cell (
         .clk          (clk),
         .por_n        (por_n),
         .burn_hit     (hit_vec[i]),
         .rst_burn_hit (rst_hit_vec[i]),
         .blown_o      (blown_vec[i]),
         .indet_o      (indet_vec[i]),
         .over_o       (over_vec[i]),
         .acc_o        (acc_arr[i])
      );
   end

   assign blown_at_burn = addr_ok ? blown_vec[burn_addr] : 1'b0;
   assign double_hit    = rst_n && burn_en && addr_ok && pulse_start && blown_at_burn;
   assign over_hit      = |over_vec;

   otp_fuse_err_latch #(.AW(AW), .KIND(ERR_KIND_DOUBLE)) u_err_double (
      .clk      (clk),
      .por_n    (por_n),
      .hit      (double_hit),
      .hit_addr (burn_addr),
      .flag_o   (err_double),
      .addr_o   (err_double_addr)
   );

   otp_fuse_err_latch #(.AW(AW), .KIND(ERR_KIND_OVERTIME)) u_err_over (
      .clk      (clk),
      .por_n    (por_n),
      .hit      (over_hit),
      .hit_addr (burn_addr),
      .flag_o   (err_overtime),
      .addr_o   (err_overtime_addr)
   );

   // Read path: combinational or registered variant
   logic rd_indet_c;
   logic rd_data_c;

   assign rd_indet_c = rd_ok ? indet_vec[rd_addr] : 1'b0;
   assign rd_data_c  = rd_indet_c ? INDET_VAL : (rd_ok ? blown_vec[rd_addr] : 1'b0);

   if (READ_REG) begin : g_rd_reg
      logic rd_data_q;
      logic rd_indet_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            rd_data_q  <= 1'b0;
            rd_indet_q <= 1'b0;
         end else begin
            rd_data_q  <= rd_data_c;
            rd_indet_q <= rd_indet_c;
         end
      end
      assign rd_data  = rd_data_q;
      assign rd_indet = rd_indet_q;
   end else begin : g_rd_comb
      assign rd_data  = rd_data_c;
      assign rd_indet = rd_indet_c;
   end

endmodule

// File: rtl/otp_fuse_chk.sv
module otp_fuse_chk #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned AW    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             por_n,
   input logic             burn_en,
   input logic [AW-1:0]    burn_addr,
   input logic             err_double,
   input logic [AW-1:0]    err_double_addr,
   input logic             err_overtime,
   input logic [AW-1:0]    err_overtime_addr,
   input logic [DEPTH-1:0] blown_vec,
   input logic [DEPTH-1:0] indet_vec
);

   // R3
   no_unblow_chk: assert property (@(posedge clk) disable iff (!por_n)
      (($past(blown_vec) & ~blown_vec) == '0));

   // R7
   blow_needs_burn_chk: assert property (@(posedge clk) disable iff (!por_n)
      (blown_vec != $past(blown_vec)) |-> $past(rst_n && burn_en));

   // R8
   indet_needs_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
      ((indet_vec & ~$past(indet_vec)) != '0) |-> $past(!rst_n && burn_en));

   // R4
   double_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(err_double) |-> $past(rst_n && burn_en));

   // R5
   over_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(err_overtime) |-> $past(rst_n && burn_en));

   // R6
   double_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      err_double |=> (err_double && $stable(err_double_addr)));

   // R6
   over_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      err_overtime |=> (err_overtime && $stable(err_overtime_addr)));

   // R5
   over_addr_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(err_overtime) |-> (err_overtime_addr == $past(burn_addr)));

endmodule

bind otp_fuse_model otp_fuse_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .por_n             (por_n),
   .burn_en           (burn_en),
   .burn_addr         (burn_addr),
   .err_double        (err_double),
   .err_double_addr   (err_double_addr),
   .err_overtime      (err_overtime),
   .err_overtime_addr (err_overtime_addr),
   .blown_vec         (blown_vec),
   .indet_vec         (indet_vec)
);

// File: tb/sim_otp_fuse_model.sv
`timescale 1ns/1ps
module sim_otp_fuse_model;

   localparam int unsigned DEPTH     = 32;
   localparam int unsigned T_MIN     = 4;
   localparam int unsigned T_MAX     = 10;
   localparam bit          INDET_VAL = 1'b1;
   localparam int unsigned AW        = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          por_n = 1'b0;
   logic [AW-1:0] burn_addr = '0;
   logic          burn_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_data;
   logic          rd_indet;
   logic          err_double;
   logic [AW-1:0] err_double_addr;
   logic          err_overtime;
   logic [AW-1:0] err_overtime_addr;

   int checks = 0;
   int errors = 0;

   // Reference state derived from the requirements
   int          acc_m   [DEPTH];
   bit          blown_m [DEPTH];
   bit          indet_m [DEPTH];
   bit          ed_m, eo_m;
   int          eda_m, eoa_m;
   bit          pen_m;
   int          pa_m;

   always #4 clk = ~clk;

   otp_fuse_model #(
      .DEPTH     (DEPTH),
      .T_MIN     (T_MIN),
      .T_MAX     (T_MAX),
      .INDET_VAL (INDET_VAL)
   ) u0 (
      .clk               (clk),
      .rst_n             (rst_n),
      .por_n             (por_n),
      .burn_addr         (burn_addr),
      .burn_en           (burn_en),
      .rd_addr           (rd_addr),
      .rd_data           (rd_data),
      .rd_indet          (rd_indet),
      .err_double        (err_double),
      .err_double_addr   (err_double_addr),
      .err_overtime      (err_overtime),
      .err_overtime_addr (err_overtime_addr)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit exp_read(input int a);
      return indet_m[a] ? INDET_VAL : blown_m[a];
   endfunction

   task automatic model_clear();
      for (int i = 0; i < DEPTH; i++) begin
         acc_m[i] = 0; blown_m[i] = 0; indet_m[i] = 0;
      end
      ed_m = 0; eo_m = 0; eda_m = 0; eoa_m = 0; pen_m = 0; pa_m = 0;
   endtask

   // One clock edge as the requirements describe it
   task automatic model_step(input bit en, input int a, input bit rst);
      if (!rst && en) indet_m[a] = 1;                       // R8
      if (rst && en) begin
         if ((!pen_m || pa_m != a) && blown_m[a] && !ed_m) begin  // R4
            ed_m = 1; eda_m = a;
         end
         if (acc_m[a] >= T_MAX && !eo_m) begin              // R5
            eo_m = 1; eoa_m = a;
         end
         if (acc_m[a] < T_MAX + 1) acc_m[a]++;              // R2
         if (acc_m[a] >= T_MIN) blown_m[a] = 1;             // R3
      end
      if (!rst) pen_m = 0;
      else begin pen_m = en; pa_m = a; end
   endtask

   // Drive one cycle at posedge+1, then wait for the next posedge+1
   task automatic tick(input bit en, input int a, input bit rst);
      burn_en = en; burn_addr = AW'(a); rst_n = rst;
      model_step(en, a, rst);
      @(posedge clk); #1;
   endtask

   task automatic burn(input int a, input int n);
      for (int k = 0; k < n; k++) tick(1'b1, a, 1'b1);
      tick(1'b0, a, 1'b1);
   endtask

   // R9: sweep every address combinationally within one clock phase
   task automatic sweep(input string req);
      for (int i = 0; i < DEPTH; i++) begin
         rd_addr = AW'(i);
         #0.1;
         check({req, " R9 rd_data"}, int'(rd_data), int'(exp_read(i)));
         check({req, " R9 rd_indet"}, int'(rd_indet), int'(indet_m[i]));
      end
   endtask

   task automatic check_err(input string req);
      check({req, " err_double"}, int'(err_double), int'(ed_m));
      if (ed_m) check({req, " err_double_addr"}, int'(err_double_addr), eda_m);
      check({req, " err_overtime"}, int'(err_overtime), int'(eo_m));
      if (eo_m) check({req, " err_overtime_addr"}, int'(err_overtime_addr), eoa_m);
   endtask

   task automatic read_one(input string req, input int a);
      rd_addr = AW'(a);
      #0.1;
      check(req, int'(rd_data), int'(exp_read(a)));
   endtask

   task automatic power_on();
      burn_en = 1'b0;
      por_n = 1'b0;
      model_clear();
      @(posedge clk); #1;
      por_n = 1'b1;
   endtask

   initial begin
      #(8ns * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      model_clear();
      repeat (3) @(posedge clk);
      #1;
      por_n = 1'b1;
      tick(1'b0, 0, 1'b0);
      tick(1'b0, 0, 1'b1);

      // R1: reset state
      sweep("R1 init");
      check_err("R1 init");

      // R3: one cycle short of T_MIN stays unblown, next cycle blows
      burn(3, T_MIN - 1);
      read_one("R3 short pulse", 3);
      burn(3, 1);
      read_one("R2 R3 accumulated", 3);
      sweep("R2 neighbours");

      // R4: continuous pulse through the blow point is not an error
      burn(5, T_MIN + 2);
      check_err("R4 continuous");
      // R4: new pulse on a blown bit
      burn(5, 1);
      check("R4 err_double", int'(err_double), 1);
      check_err("R4 double");

      // R4: address switch while held is a new pulse
      burn(7, 2);
      tick(1'b1, 6, 1'b1);
      tick(1'b1, 3, 1'b1);
      tick(1'b0, 3, 1'b1);
      check_err("R4 R6 switch");

      // R5: T_MAX cycles fine, T_MAX+1 flags
      burn(9, T_MAX);
      check("R5 at T_MAX", int'(err_overtime), 0);
      burn(9, 1);
      check("R5 over", int'(err_overtime), 1);
      check_err("R5 over");

      // R6: later offender does not move the address
      burn(12, T_MAX + 2);
      check_err("R6 sticky");

      // R7: controller reset keeps everything
      tick(1'b0, 0, 1'b0);
      tick(1'b0, 0, 1'b0);
      tick(1'b0, 0, 1'b1);
      sweep("R7 ctrl reset");
      check_err("R7 ctrl reset");

      // R8: reset while burning marks indeterminate
      tick(1'b1, 20, 1'b0);
      tick(1'b1, 20, 1'b0);
      tick(1'b0, 20, 1'b1);
      read_one("R8 indet data", 20);
      rd_addr = AW'(20); #0.1;
      check("R8 indet flag", int'(rd_indet), 1);
      sweep("R8 sweep");

      // R7: power-on initialisation clears everything
      power_on();
      tick(1'b0, 0, 1'b1);
      sweep("R7 por");
      check_err("R7 por");

      // Random phase
      for (int n = 0; n < 300; n++) begin
         int a;
         int len;
         int sel;
         a   = int'($urandom_range(DEPTH - 1, 0));
         len = int'($urandom_range(T_MAX + 2, 1));
         sel = int'($urandom_range(19, 0));
         if (sel == 0) begin
            tick(1'b1, a, 1'b0);
            tick(1'b0, a, 1'b1);
         end else if (sel == 1 && n > 150) begin
            power_on();
         end else begin
            burn(a, len);
         end
         if (n % 10 == 9) sweep("R2 R3 R8 random");
         else read_one("R3 random", a);
         check_err("R4 R5 R6 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule